// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block recovers characters from an idle-high NRZ serial line. A shared rate generator supplies a one-cycle `tick` at sixteen times the bit rate. On each tick the block samples a two-flop synchronised copy of the line. A falling edge is accepted as the start of a character only if the line is still low at a majority of three later check points. Narrow low pulses are therefore discarded. Each following bit is resolved by a two-of-three vote near the middle of its cell, and any disagreement among the three samples is reported as noise.

A character holds 8 or 9 word bits, sent least significant bit first, followed by one stop bit. When parity is enabled, the most significant word bit is the parity bit and the word is checked for even or odd parity. Finished characters are offered on a valid/ready output. The block also gives per-character error flags, a sticky overrun flag, a one-cycle idle-line pulse, and a sleep state. The sleep state lets the host skip traffic meant for other listeners. It ends either on an idle line or on a character whose top word bit is set.

Back-pressure rules: `rx_valid` means the output holder is full. While `rx_valid` is high and `rx_ready` is low, `rx_data` and the three character flags stay unchanged. A character that completes in that state is dropped and `err_overrun` is raised. The holder empties in a cycle where `rx_valid` and `rx_ready` are both high. A character that completes in that same cycle is accepted.

Top module: `serial_rx`

## Requirements
- R1: After reset `rx_valid`, `asleep`, `idle_pulse` and every error flag are low.
- R2: A character with 8 word bits (`word9`=0) or 9 word bits (`word9`=1), sent LSB first after a low start bit, appears on `rx_data` with word bit i at position i. In 8-bit mode bit 8 is 0.
- R3: A low pulse of 1 to 4 tick periods is ignored. Start is confirmed only if at most one of the samples at ticks 3, 5 and 7 after the falling edge is high.
- R4: Each word bit and the stop bit is the majority of the samples at ticks 8, 9 and 10 of its cell. If those samples disagree in any bit of a character, `err_noise` is raised for that character. A disagreeing sample outside that window has no effect.
- R5: A stop bit resolved low raises `err_frame`, and the character is still delivered.
- R6: With `par_en`=1, the most significant word bit is the parity bit. `err_parity` is raised when the count of ones in the whole word is odd with `par_odd`=0, or even with `par_odd`=1. With `par_en`=0 it stays low.
- R7: `rx_valid` stays high with `rx_data` stable until accepted with `rx_ready`. The three character flags are low whenever `rx_valid` is low.
- R8: A character that completes while `rx_valid`=1 and `rx_ready`=0 is discarded and raises `err_overrun`. The held data is kept, and `err_overrun` clears when the holder is emptied.
- R9: After a received character, `idle_pulse` is high for one cycle once the line has been high for (word bits + 2) x 16 ticks. It does not pulse again until another character is received.
- R10: While `rx_en`=0, no character is delivered.
- R11: `sleep_req` puts the block to sleep (`asleep`=1). Characters are not delivered while asleep. With `wake_addr`=0, sleep ends after (word bits + 2) x 16 ticks of continuous high line, and that idle time produces no `idle_pulse`.
- R12: With `wake_addr`=1, a character whose most significant word bit (bit 7, or bit 8 when `word9`=1) is clear is ignored while asleep. One with that bit set ends sleep and is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversampling strobe, 16 per bit |
| rx_in | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receiver enable |
| word9 | input | 1 | 1 selects 9 word bits, 0 selects 8 |
| par_en | input | 1 | Parity check enable |
| par_odd | input | 1 | 1 odd parity, 0 even |
| wake_addr | input | 1 | Sleep exit: 1 on address bit, 0 on idle line |
| sleep_req | input | 1 | One-cycle request to enter sleep |
| rx_valid | output | 1 | Output holder full |
| rx_ready | input | 1 | Consumer accepts the held character |
| rx_data | output | 9 | Received word |
| err_noise | output | 1 | Sample disagreement in held character |
| err_frame | output | 1 | Stop bit low in held character |
| err_parity | output | 1 | Parity mismatch in held character |
| err_overrun | output | 1 | A character was lost while full |
| idle_pulse | output | 1 | One-cycle idle-line indication |
| asleep | output | 1 | Sleep state |

## Verification
With `tick` high every cycle, a character's result is registered 13 cycles after its stop cell begins on `rx_in`. That is two synchroniser stages, the tenth stop-bit sample, and one output register. The bench therefore samples at the falling edge that ends the 16-cycle stop cell, before the next character starts. It then empties the holder one cycle later and confirms it is empty. The idle pulse is due (word bits + 2) x 16 ticks after the stop sample. The bench checks for it once well inside that window and once well past it. It checks the wake from idle sleep the same way. Glitch and disabled-receiver checks wait longer than a full character before testing that nothing appeared.

// File: rtl/serial_rx_pkg.sv
`timescale 1ns/1ps
package serial_rx_pkg;
  typedef enum logic [1:0] {RX_HUNT, RX_START, RX_DATA, RX_STOP} rx_state_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic split3(input logic a, input logic b, input logic c);
    return (a ^ b) | (b ^ c);
  endfunction
endpackage

// File: rtl/serial_rx_sync.sv
`timescale 1ns/1ps
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else        chain[i] <= (i == 0) ? din : chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_framer.sv
`timescale 1ns/1ps
module serial_rx_framer import serial_rx_pkg::*; #(
  parameter int OSR  = 16,
  parameter int WMAX = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            en,
  input  logic            rxs,
  input  logic            word9,
  output logic            frame_done,
  output logic [WMAX-1:0] word_q,
  output logic            noise_q,
  output logic            stop_bad_q,
  output logic            hunting
);
  localparam int PW = $clog2(OSR);
  localparam int BW = $clog2(WMAX);
  localparam logic [PW-1:0] P_QA   = PW'(OSR/8);
  localparam logic [PW-1:0] P_QB   = PW'(OSR/4);
  localparam logic [PW-1:0] P_QC   = PW'(3*OSR/8);
  localparam logic [PW-1:0] P_MA   = PW'(OSR/2 - 1);
  localparam logic [PW-1:0] P_MB   = PW'(OSR/2);
  localparam logic [PW-1:0] P_MC   = PW'(OSR/2 + 1);
  localparam logic [PW-1:0] P_LAST = PW'(OSR - 1);

  rx_state_e       st;
  logic [PW-1:0]   ph;
  logic [BW-1:0]   bidx;
  logic [BW-1:0]   last_bit;
  logic            s_a, s_b, prev_hi, nz;
  logic [WMAX-1:0] acc;
  logic            maj, odd_one;

  assign last_bit = word9 ? BW'(WMAX-1) : BW'(WMAX-2);
  assign maj      = vote3(s_a, s_b, rxs);
  assign odd_one  = split3(s_a, s_b, rxs);
  assign hunting  = (st == RX_HUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= RX_HUNT;
      ph         <= '0;
      bidx       <= '0;
      s_a        <= 1'b1;
      s_b        <= 1'b1;
      prev_hi    <= 1'b0;
      nz         <= 1'b0;
      acc        <= '0;
      frame_done <= 1'b0;
      word_q     <= '0;
      noise_q    <= 1'b0;
      stop_bad_q <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (!en) begin
        st      <= RX_HUNT;
        ph      <= '0;
        prev_hi <= 1'b0;
      end else if (tick) begin
        ph <= (ph == P_LAST) ? '0 : ph + 1'b1;
        unique case (st)
          RX_HUNT: begin
            prev_hi <= rxs;
            if (prev_hi && !rxs) begin
              st  <= RX_START;
              ph  <= PW'(1);
              acc <= '0;
              nz  <= 1'b0;
            end
          end
          RX_START: begin
            if (ph == P_QA) s_a <= rxs;
            if (ph == P_QB) s_b <= rxs;
            if (ph == P_QC && maj) begin
              st      <= RX_HUNT;
              prev_hi <= rxs;
            end else if (ph == P_LAST) begin
              st   <= RX_DATA;
              bidx <= '0;
            end
          end
          RX_DATA: begin
            if (ph == P_MA) s_a <= rxs;
            if (ph == P_MB) s_b <= rxs;
            if (ph == P_MC) begin
              acc[bidx] <= maj;
              nz        <= nz | odd_one;
            end
            if (ph == P_LAST) begin
              if (bidx == last_bit) st <= RX_STOP;
              else                  bidx <= bidx + 1'b1;
            end
          end
          RX_STOP: begin
            if (ph == P_MA) s_a <= rxs;
            if (ph == P_MB) s_b <= rxs;
            if (ph == P_MC) begin
              frame_done <= 1'b1;
              word_q     <= acc;
              noise_q    <= nz | odd_one;
              stop_bad_q <= !maj;
              st         <= RX_HUNT;
              prev_hi    <= rxs;
            end
          end
          default: st <= RX_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_rx_idle.sv
`timescale 1ns/1ps
module serial_rx_idle #(
  parameter int OSR  = 16,
  parameter int WMAX = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic rxs,
  input  logic hunting,
  input  logic word9,
  input  logic frame_done,
  input  logic restart,
  input  logic asleep,
  output logic idle_hit,
  output logic idle_pulse
);
  localparam int CW = $clog2((WMAX + 2) * OSR + 1);
  localparam logic [CW-1:0] LIM9 = CW'((WMAX + 2) * OSR);
  localparam logic [CW-1:0] LIM8 = CW'((WMAX + 1) * OSR);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          armed;
  logic          high_tick;

  assign lim       = word9 ? LIM9 : LIM8;
  assign high_tick = en && !restart && tick && hunting && rxs;
  assign idle_hit  = high_tick && (cnt == lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      armed      <= 1'b0;
      idle_pulse <= 1'b0;
    end else begin
      idle_pulse <= idle_hit && armed && !asleep;
      if (!en || restart)        cnt <= '0;
      else if (high_tick)        cnt <= (cnt == lim) ? cnt : cnt + 1'b1;
      else if (tick)             cnt <= '0;
      if (frame_done)            armed <= 1'b1;
      else if (idle_hit)         armed <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_out.sv
`timescale 1ns/1ps
module serial_rx_out #(
  parameter int WMAX = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            frame_done,
  input  logic [WMAX-1:0] word,
  input  logic            noise,
  input  logic            stop_bad,
  input  logic            word9,
  input  logic            par_en,
  input  logic            par_odd,
  input  logic            wake_addr,
  input  logic            sleep_req,
  input  logic            idle_hit,
  input  logic            rx_ready,
  output logic            rx_valid,
  output logic [WMAX-1:0] rx_data,
  output logic            err_noise,
  output logic            err_frame,
  output logic            err_parity,
  output logic            err_overrun,
  output logic            asleep,
  output logic            sleep_start
);
  logic msb, perr, addr_hit, take, full, pop;

  assign msb         = word9 ? word[WMAX-1] : word[WMAX-2];
  assign perr        = par_en && ((^word) ^ par_odd);
  assign addr_hit    = asleep && wake_addr && frame_done && msb;
  assign take        = en && frame_done && (!asleep || addr_hit);
  assign full        = rx_valid && !rx_ready;
  assign pop         = rx_valid && rx_ready;
  assign sleep_start = en && sleep_req && !asleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep <= 1'b0;
    end else if (!en) begin
      asleep <= 1'b0;
    end else if (sleep_start) begin
      asleep <= 1'b1;
    end else if (addr_hit || (asleep && !wake_addr && idle_hit)) begin
      asleep <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid    <= 1'b0;
      rx_data     <= '0;
      err_noise   <= 1'b0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
    end else if (take && full) begin
      err_overrun <= 1'b1;
    end else if (take) begin
      rx_valid    <= 1'b1;
      rx_data     <= word;
      err_noise   <= noise;
      err_frame   <= stop_bad;
      err_parity  <= perr;
      err_overrun <= 1'b0;
    end else if (pop) begin
      rx_valid    <= 1'b0;
      err_noise   <= 1'b0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx.sv
`timescale 1ns/1ps
module serial_rx #(
  parameter int OSR       = 16,
  parameter int WMAX      = 9,
  parameter int SYNC_STGS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            rx_in,
  input  logic            rx_en,
  input  logic            word9,
  input  logic            par_en,
  input  logic            par_odd,
  input  logic            wake_addr,
  input  logic            sleep_req,
  output logic            rx_valid,
  input  logic            rx_ready,
  output logic [WMAX-1:0] rx_data,
  output logic            err_noise,
  output logic            err_frame,
  output logic            err_parity,
  output logic            err_overrun,
  output logic            idle_pulse,
  output logic            asleep
);
  logic            rxs;
  logic            frame_done, noise_q, stop_bad_q, hunting;
  logic [WMAX-1:0] word_q;
  logic            idle_hit, sleep_start;

  serial_rx_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(rxs)
  );

  serial_rx_framer #(.OSR(OSR), .WMAX(WMAX)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(rx_en), .rxs(rxs),
    .word9(word9), .frame_done(frame_done), .word_q(word_q),
    .noise_q(noise_q), .stop_bad_q(stop_bad_q), .hunting(hunting)
  );

  serial_rx_idle #(.OSR(OSR), .WMAX(WMAX)) u_idle (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(rx_en), .rxs(rxs),
    .hunting(hunting), .word9(word9), .frame_done(frame_done),
    .restart(sleep_start), .asleep(asleep), .idle_hit(idle_hit),
    .idle_pulse(idle_pulse)
  );

  serial_rx_out #(.WMAX(WMAX)) u_out (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .frame_done(frame_done),
    .word(word_q), .noise(noise_q), .stop_bad(stop_bad_q), .word9(word9),
    .par_en(par_en), .par_odd(par_odd), .wake_addr(wake_addr),
    .sleep_req(sleep_req), .idle_hit(idle_hit), .rx_ready(rx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .err_noise(err_noise),
    .err_frame(err_frame), .err_parity(err_parity),
    .err_overrun(err_overrun), .asleep(asleep), .sleep_start(sleep_start)
  );
endmodule

// File: rtl/serial_rx_chk.sv
`timescale 1ns/1ps
module serial_rx_chk #(
  parameter int WMAX = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rx_en,
  input logic            word9,
  input logic            rx_valid,
  input logic            rx_ready,
  input logic [WMAX-1:0] rx_data,
  input logic            err_noise,
  input logic            err_frame,
  input logic            err_parity,
  input logic            err_overrun,
  input logic            idle_pulse,
  input logic            asleep
);
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  // R7
  flags_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> !(err_noise || err_frame || err_parity));

  // R8
  overrun_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun |-> rx_valid);

  // R9
  idle_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_pulse |=> !idle_pulse);

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !$rose(rx_valid));

  // R11
  sleep_no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_pulse |-> !$past(asleep));

  // R12
  addr_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) && $past(asleep) |-> (word9 ? rx_data[WMAX-1] : rx_data[WMAX-2]));
endmodule

bind serial_rx serial_rx_chk #(.WMAX(WMAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .word9(word9),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .err_noise(err_noise), .err_frame(err_frame), .err_parity(err_parity),
  .err_overrun(err_overrun), .idle_pulse(idle_pulse), .asleep(asleep)
);

// File: tb/serial_rx_bench.sv
`timescale 1ns/1ps
module serial_rx_bench;
  localparam int OSR = 16;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, rx_in = 1'b1, rx_en = 1'b0;
  logic word9 = 1'b0, par_en = 1'b0, par_odd = 1'b0, wake_addr = 1'b0;
  logic sleep_req = 1'b0, rx_ready = 1'b0;
  logic rx_valid, err_noise, err_frame, err_parity, err_overrun, idle_pulse, asleep;
  logic [8:0] rx_data;

  int nvec = 0, nfail = 0, idle_seen = 0;

  serial_rx u_serial_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_in(rx_in), .rx_en(rx_en),
    .word9(word9), .par_en(par_en), .par_odd(par_odd), .wake_addr(wake_addr),
    .sleep_req(sleep_req), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .err_noise(err_noise), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun),
    .idle_pulse(idle_pulse), .asleep(asleep)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (idle_pulse) idle_seen++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nbit selects the cell to disturb (nb = stop bit, -1 = none), noff the cycle in it
  task automatic send(input logic [8:0] w, input int nb, input logic stopv,
                      input int nbit, input int noff);
    rx_in = 1'b0;
    cyc(OSR);
    for (int b = 0; b < nb; b++) begin
      for (int k = 0; k < OSR; k++) begin
        rx_in = (b == nbit && k == noff) ? ~w[b] : w[b];
        cyc(1);
      end
    end
    for (int k = 0; k < OSR; k++) begin
      rx_in = (nbit == nb && k == noff) ? ~stopv : stopv;
      cyc(1);
    end
    rx_in = 1'b1;
  endtask

  task automatic pop();
    rx_ready = 1'b1;
    cyc(1);
    rx_ready = 1'b0;
  endtask

  task automatic expect_frame(input logic [8:0] w, input logic nz, input logic fe,
                              input logic pe);
    chk("R7 valid", 32'(rx_valid), 32'd1);
    chk("R2 data", 32'(rx_data), 32'(w));
    chk("R4 noise", 32'(err_noise), 32'(nz));
    chk("R5 framing", 32'(err_frame), 32'(fe));
    chk("R6 parity", 32'(err_parity), 32'(pe));
    pop();
    chk("R7 drained", 32'(rx_valid), 32'd0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nvec++;
    nfail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    // R1
    chk("R1 valid", 32'(rx_valid), 32'd0);
    chk("R1 asleep", 32'(asleep), 32'd0);
    chk("R1 flags", 32'({err_noise, err_frame, err_parity, err_overrun, idle_pulse}), 32'd0);
    rst_n = 1'b1;
    rx_en = 1'b1;
    cyc(5);

    // R2 R6: all 8-bit values, parity mode rotating, some with a bad parity bit
    for (int v = 0; v < 256; v++) begin
      logic [8:0] w;
      logic pe;
      w = 9'(v);
      pe = 1'b0;
      par_en = (v % 3) != 0;
      par_odd = (v % 3) == 2;
      if (par_en) begin
        w[7] = (^w[6:0]) ^ par_odd;
        if (v % 7 == 0) begin
          w[7] = ~w[7];
          pe = 1'b1;
        end
      end
      send(w, 8, 1'b1, -1, 0);
      expect_frame(w, 1'b0, 1'b0, pe);
    end

    // R2 nine-bit words, no parity
    par_en = 1'b0;
    word9 = 1'b1;
    for (int i = 0; i < 6; i++) begin
      logic [8:0] w;
      w = 9'((i * 9'h0B5) ^ (i[0] ? 9'h1FF : 9'h100));
      send(w, 9, 1'b1, -1, 0);
      expect_frame(w, 1'b0, 1'b0, 1'b0);
    end
    // R6 nine-bit odd parity, good then bad
    par_en = 1'b1;
    par_odd = 1'b1;
    begin
      logic [8:0] w;
      w = {(^8'hF3) ^ 1'b1, 8'hF3};
      send(w, 9, 1'b1, -1, 0);
      expect_frame(w, 1'b0, 1'b0, 1'b0);
      w[8] = ~w[8];
      send(w, 9, 1'b1, -1, 0);
      expect_frame(w, 1'b0, 1'b0, 1'b1);
    end
    par_en = 1'b0;
    par_odd = 1'b0;
    word9 = 1'b0;

    // R4 one disturbed sample in each vote slot of every cell
    for (int b = 0; b <= 8; b++) begin
      for (int off = 7; off <= 9; off++) begin
        logic [8:0] w;
        w = 9'(8'h5A ^ 8'(b * 17 + off));
        send(w, 8, 1'b1, b, off);
        expect_frame(w, 1'b1, 1'b0, 1'b0);
      end
    end
    // R4 disturbance outside the vote window
    send(9'h0C3, 8, 1'b1, 2, 3);
    expect_frame(9'h0C3, 1'b0, 1'b0, 1'b0);
    send(9'h03C, 8, 1'b1, 5, 13);
    expect_frame(9'h03C, 1'b0, 1'b0, 1'b0);

    // R5 stop bit low, and an all-low break
    send(9'h03C, 8, 1'b0, -1, 0);
    expect_frame(9'h03C, 1'b0, 1'b1, 1'b0);
    cyc(32);
    send(9'h000, 8, 1'b0, -1, 0);
    expect_frame(9'h000, 1'b0, 1'b1, 1'b0);
    cyc(32);

    // R3 short low pulses rejected
    for (int len = 1; len <= 4; len++) begin
      rx_in = 1'b0;
      cyc(len);
      rx_in = 1'b1;
      cyc(12 * OSR);
      chk("R3 glitch ignored", 32'(rx_valid), 32'd0);
    end
    send(9'h081, 8, 1'b1, -1, 0);
    expect_frame(9'h081, 1'b0, 1'b0, 1'b0);

    // R8 overrun
    send(9'h011, 8, 1'b1, -1, 0);
    send(9'h022, 8, 1'b1, -1, 0);
    chk("R8 kept valid", 32'(rx_valid), 32'd1);
    chk("R8 kept data", 32'(rx_data), 32'h011);
    chk("R8 overrun", 32'(err_overrun), 32'd1);
    pop();
    chk("R8 overrun cleared", 32'(err_overrun), 32'd0);
    chk("R8 empty", 32'(rx_valid), 32'd0);

    // R9 idle pulse once
    begin
      int base;
      send(9'h033, 8, 1'b1, -1, 0);
      expect_frame(9'h033, 1'b0, 1'b0, 1'b0);
      base = idle_seen;
      cyc(100);
      chk("R9 not early", 32'(idle_seen - base), 32'd0);
      cyc(300);
      chk("R9 one pulse", 32'(idle_seen - base), 32'd1);
      cyc(400);
      chk("R9 no repeat", 32'(idle_seen - base), 32'd1);
    end

    // R10 disabled receiver
    rx_en = 1'b0;
    send(9'h044, 8, 1'b1, -1, 0);
    cyc(4);
    chk("R10 disabled", 32'(rx_valid), 32'd0);
    rx_en = 1'b1;
    cyc(5);

    // R11 idle-line wake
    begin
      int base;
      wake_addr = 1'b0;
      base = idle_seen;
      sleep_req = 1'b1;
      cyc(1);
      sleep_req = 1'b0;
      chk("R11 asleep", 32'(asleep), 32'd1);
      send(9'h055, 8, 1'b1, -1, 0);
      chk("R11 not delivered", 32'(rx_valid), 32'd0);
      cyc(100);
      chk("R11 still asleep", 32'(asleep), 32'd1);
      cyc(120);
      chk("R11 woke", 32'(asleep), 32'd0);
      cyc(400);
      chk("R11 no idle pulse", 32'(idle_seen - base), 32'd0);
      send(9'h066, 8, 1'b1, -1, 0);
      expect_frame(9'h066, 1'b0, 1'b0, 1'b0);
    end

    // R12 address-mark wake, 8-bit then 9-bit
    wake_addr = 1'b1;
    sleep_req = 1'b1;
    cyc(1);
    sleep_req = 1'b0;
    send(9'h035, 8, 1'b1, -1, 0);
    chk("R12 ignored", 32'(rx_valid), 32'd0);
    chk("R12 still asleep", 32'(asleep), 32'd1);
    cyc(300);
    chk("R12 idle keeps sleep", 32'(asleep), 32'd1);
    send(9'h0A5, 8, 1'b1, -1, 0);
    chk("R12 awake", 32'(asleep), 32'd0);
    expect_frame(9'h0A5, 1'b0, 1'b0, 1'b0);
    word9 = 1'b1;
    sleep_req = 1'b1;
    cyc(1);
    sleep_req = 1'b0;
    send(9'h0FF, 9, 1'b1, -1, 0);
    chk("R12 nine-bit ignored", 32'(rx_valid), 32'd0);
    send(9'h101, 9, 1'b1, -1, 0);
    chk("R12 nine-bit awake", 32'(asleep), 32'd0);
    expect_frame(9'h101, 1'b0, 1'b0, 1'b0);

    cyc(10);
    finish_run();
  end
endmodule